// File: doc/BRIEF.md
# Throttled Looping Trigger Playback Generator

This block holds a byte-wide slice image loaded by a host. Once started, it replays that image one slice per bunch clock in an endless loop. Two bits of every slice drive control outputs: bit 0 is a trigger-accept strobe and bit 1 is an orbit-start marker that downstream bunch counters use to clear themselves. The loop length is a whole number of orbits, and one orbit is a whole number of fixed-size slice units. When the read position reaches the end of the loop, it returns to slice zero by itself, so the replay stays aligned with other playback memories that loop over the same number of orbits.

With a single trigger bit per pass, the lowest trigger rate is one strobe per pass. To go below that, the host sets a burst size M and a pause length N. After every M slices it outputs, the block goes idle for exactly N whole orbits. It then continues from the slice where it stopped. Because the pause is a whole number of orbits, the orbit phase is unchanged across it.

The sequencer has three states. STOPPED is the reset state, and the only state in which host writes reach the image. RUNNING outputs one slice per clock. PAUSED drives both outputs low while a dedicated orbit timer counts out the pause. The transitions are: start (STOPPED to RUNNING; in RUNNING or PAUSED it restarts); burst-complete (RUNNING to PAUSED); pause-complete (PAUSED to RUNNING); stop (any state to STOPPED). The state is visible on a status output. A counter reports the number of trigger strobes issued since the last start.

Top module: `ptg_playback_gen`

## Requirements
- R1: After reset, run_status is STOPPED (2'b00), trig_out and orbit_mark are low, and trig_count is zero.
- R2: A host write (host_we high at a clock edge) stores host_data at host_addr only when run_status is STOPPED. A write presented while RUNNING or PAUSED leaves the image unchanged.
- R3: When start_cmd is high and stop_cmd is low at edge e0, the state becomes RUNNING. Slice k of the playback sequence drives trig_out (slice bit 0) and orbit_mark (slice bit 1) during the cycle after edge e0+k+1, with one slice per clock in increasing address order.
- R4: The loop length is orbit_units*UNIT*loop_orbits slices, with a value of 0 in either field treated as 1. After the last slice of the loop, the next slice output is address 0, with no host action. The address also wraps naturally at the end of the memory.
- R5: When burst_slices and pause_orbits are both nonzero, then after every burst_slices slices output, run_status is PAUSED and both outputs are low for exactly pause_orbits*orbit_units*UNIT clocks. Output then resumes with the next slice in sequence.
- R6: When burst_slices or pause_orbits is zero, the block never enters PAUSED and the output is continuous.
- R7: Start taken in any state (including mid-pause) resets the read address, the burst and pause counters, and trig_count. Playback then restarts from slice 0 as in R3.
- R8: A stop at an edge moves the state to STOPPED, and both outputs are low from the following cycle. When start and stop arrive together, stop wins.
- R9: At every clock, trig_count equals the number of cycles since the last start in which trig_out was high, up to and not including the current cycle. The count wraps modulo 2^CNT_W.
- R10: run_status encodes STOPPED=2'b00, RUNNING=2'b01, PAUSED=2'b10, and never shows 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_cmd | input | 1 | Start or restart playback from slice 0 |
| stop_cmd | input | 1 | Stop playback; has priority over start |
| host_we | input | 1 | Host write strobe for the slice image |
| host_addr | input | ADDR_W | Host write address |
| host_data | input | 8 | Host write slice byte |
| orbit_units | input | UNITS_W | Orbit length in units of UNIT slices |
| loop_orbits | input | LOOP_W | Loop length in orbits |
| burst_slices | input | BURST_W | Slices output between pauses (M) |
| pause_orbits | input | PAUSE_W | Orbits per pause (N) |
| trig_out | output | 1 | Trigger-accept strobe (slice bit 0) |
| orbit_mark | output | 1 | Orbit-start marker (slice bit 1) |
| run_status | output | 2 | Sequencer state |
| trig_count | output | CNT_W | Trigger strobes since start |

## Verification
The bench builds the block with a 1024-slice memory (ADDR_W=10), a 16-slice orbit unit (UNIT=16), and narrow fields for orbit, loop, burst and pause counts. With these values an orbit is 16 to 64 clocks, so a run of a few hundred cycles passes several loop wraps, pause entries and pause exits. A full-memory loop, which ends at the natural address wrap, also fits within about a thousand cycles. Random configurations are mixed with directed cases for pause boundaries, restart mid-pause, stop and start arriving together, and writes attempted during playback.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

    typedef enum logic [1:0] {
        PB_STOPPED = 2'b00,
        PB_RUNNING = 2'b01,
        PB_PAUSED  = 2'b10
    } pb_state_e;

    localparam int SLICE_W  = 8;
    localparam int TRIG_BIT = 0;
    localparam int MARK_BIT = 1;

endpackage

// File: rtl/ptg_slice_mem.sv
module ptg_slice_mem #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
        rdata <= store[raddr];
    end
endmodule

// File: rtl/ptg_orbit_timer.sv
module ptg_orbit_timer #(
    parameter int UNIT    = 256,
    parameter int UNITS_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               en,
    input  logic [UNITS_W-1:0] units,
    output logic               last
);
    localparam int SUB_W = $clog2(UNIT);

    logic [SUB_W-1:0]   sub_q;
    logic [UNITS_W-1:0] uidx_q;
    logic               sub_end;
    logic               uidx_end;

    assign sub_end  = (sub_q == SUB_W'(UNIT - 1));
    assign uidx_end = (units == '0) || (uidx_q == units - UNITS_W'(1));
    assign last     = sub_end && uidx_end;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sub_q  <= '0;
            uidx_q <= '0;
        end else if (en) begin
            if (last) begin
                sub_q  <= '0;
                uidx_q <= '0;
            end else if (sub_end) begin
                sub_q  <= '0;
                uidx_q <= uidx_q + UNITS_W'(1);
            end else begin
                sub_q  <= sub_q + SUB_W'(1);
            end
        end
    end
endmodule

// File: rtl/ptg_playback_gen.sv
module ptg_playback_gen
    import ptg_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int UNIT    = 256,
    parameter int UNITS_W = 4,
    parameter int LOOP_W  = 8,
    parameter int BURST_W = 16,
    parameter int PAUSE_W = 8,
    parameter int CNT_W   = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_cmd,
    input  logic               stop_cmd,
    input  logic               host_we,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [7:0]         host_data,
    input  logic [UNITS_W-1:0] orbit_units,
    input  logic [LOOP_W-1:0]  loop_orbits,
    input  logic [BURST_W-1:0] burst_slices,
    input  logic [PAUSE_W-1:0] pause_orbits,
    output logic               trig_out,
    output logic               orbit_mark,
    output logic [1:0]         run_status,
    output logic [CNT_W-1:0]   trig_count
);
    pb_state_e          state_q, state_d;
    logic               go, step, pause_en, throttle_on;
    logic               burst_done, pause_done;
    logic               orbit_last, pause_last, loop_last;
    logic [ADDR_W-1:0]  addr_q;
    logic [LOOP_W-1:0]  orb_idx_q;
    logic [BURST_W-1:0] burst_q;
    logic [PAUSE_W-1:0] pcnt_q;
    logic [SLICE_W-1:0] slice_q;
    logic               live_q;

    assign go          = start_cmd && !stop_cmd;
    assign step        = (state_q == PB_RUNNING) && !start_cmd && !stop_cmd;
    assign pause_en    = (state_q == PB_PAUSED) && !start_cmd && !stop_cmd;
    assign throttle_on = (burst_slices != '0) && (pause_orbits != '0);
    assign burst_done  = step && throttle_on && (burst_q == burst_slices - BURST_W'(1));
    assign pause_done  = pause_en && pause_last && (pcnt_q == pause_orbits - PAUSE_W'(1));
    assign loop_last   = (loop_orbits == '0) || (orb_idx_q == loop_orbits - LOOP_W'(1));

    ptg_slice_mem #(
        .ADDR_W (ADDR_W),
        .DATA_W (SLICE_W)
    ) u_mem (
        .clk   (clk),
        .we    (host_we && (state_q == PB_STOPPED)),
        .waddr (host_addr),
        .wdata (host_data),
        .raddr (addr_q),
        .rdata (slice_q)
    );

    ptg_orbit_timer #(
        .UNIT    (UNIT),
        .UNITS_W (UNITS_W)
    ) u_phase_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (go),
        .en    (step),
        .units (orbit_units),
        .last  (orbit_last)
    );

    ptg_orbit_timer #(
        .UNIT    (UNIT),
        .UNITS_W (UNITS_W)
    ) u_pause_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!pause_en),
        .en    (pause_en),
        .units (orbit_units),
        .last  (pause_last)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PB_STOPPED: if (go) state_d = PB_RUNNING;
            PB_RUNNING: begin
                if (stop_cmd)        state_d = PB_STOPPED;
                else if (start_cmd)  state_d = PB_RUNNING;
                else if (burst_done) state_d = PB_PAUSED;
            end
            PB_PAUSED: begin
                if (stop_cmd)        state_d = PB_STOPPED;
                else if (start_cmd)  state_d = PB_RUNNING;
                else if (pause_done) state_d = PB_RUNNING;
            end
            default: state_d = PB_STOPPED;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PB_STOPPED;
        else        state_q <= state_d;
    end

    // Address, loop, burst and pause counters
    always_ff @(posedge clk) begin
        if (!rst_n || go) begin
            addr_q    <= '0;
            orb_idx_q <= '0;
            burst_q   <= '0;
        end else if (step) begin
            if (orbit_last && loop_last) begin
                addr_q    <= '0;
                orb_idx_q <= '0;
            end else begin
                addr_q    <= addr_q + ADDR_W'(1);
                orb_idx_q <= orb_idx_q + LOOP_W'(orbit_last);
            end
            burst_q <= burst_done ? '0 : burst_q + BURST_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !pause_en) pcnt_q <= '0;
        else if (pause_last)     pcnt_q <= pcnt_q + PAUSE_W'(1);
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q     <= 1'b0;
            trig_count <= '0;
        end else begin
            live_q <= step;
            if (go) trig_count <= '0;
            else    trig_count <= trig_count + CNT_W'(trig_out);
        end
    end

    assign trig_out   = live_q && slice_q[TRIG_BIT];
    assign orbit_mark = live_q && slice_q[MARK_BIT];
    assign run_status = state_q;
endmodule

// File: rtl/ptg_playback_gen_chk.sv
module ptg_playback_gen_chk #(
    parameter int ADDR_W  = 11,
    parameter int UNITS_W = 4,
    parameter int LOOP_W  = 8,
    parameter int BURST_W = 16,
    parameter int PAUSE_W = 8,
    parameter int CNT_W   = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_cmd,
    input logic               stop_cmd,
    input logic [BURST_W-1:0] burst_slices,
    input logic [PAUSE_W-1:0] pause_orbits,
    input logic               trig_out,
    input logic               orbit_mark,
    input logic [1:0]         run_status,
    input logic [CNT_W-1:0]   trig_count
);
    assert_quiet_in_pause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_status == 2'b10) |=> (!trig_out && !orbit_mark));

    assert_no_pause_unthrottled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((run_status == 2'b01) && !start_cmd && !stop_cmd &&
         ((burst_slices == '0) || (pause_orbits == '0))) |=> (run_status == 2'b01));

    assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_cmd && !stop_cmd) |=> ((run_status == 2'b01) && (trig_count == '0) && !trig_out));

    assert_stop_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cmd |=> (run_status == 2'b00));

    assert_quiet_when_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_status == 2'b00) |=> (!trig_out && !orbit_mark));

    assert_count_tracks_strobes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(start_cmd && !stop_cmd)) |->
            (trig_count == $past(trig_count) + CNT_W'($past(trig_out))));

    assert_status_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        run_status != 2'b11);
endmodule

bind ptg_playback_gen ptg_playback_gen_chk #(
    .ADDR_W  (ADDR_W),
    .UNITS_W (UNITS_W),
    .LOOP_W  (LOOP_W),
    .BURST_W (BURST_W),
    .PAUSE_W (PAUSE_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_cmd    (start_cmd),
    .stop_cmd     (stop_cmd),
    .burst_slices (burst_slices),
    .pause_orbits (pause_orbits),
    .trig_out     (trig_out),
    .orbit_mark   (orbit_mark),
    .run_status   (run_status),
    .trig_count   (trig_count)
);

// File: tb/ptg_playback_gen_test.sv
module ptg_playback_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W  = 10;
    localparam int UNIT    = 16;
    localparam int UNITS_W = 3;
    localparam int LOOP_W  = 7;
    localparam int BURST_W = 8;
    localparam int PAUSE_W = 3;
    localparam int CNT_W   = 16;
    localparam int DEPTH   = 1 << ADDR_W;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start_cmd = 1'b0;
    logic               stop_cmd = 1'b0;
    logic               host_we = 1'b0;
    logic [ADDR_W-1:0]  host_addr = '0;
    logic [7:0]         host_data = '0;
    logic [UNITS_W-1:0] orbit_units = 3'd1;
    logic [LOOP_W-1:0]  loop_orbits = 7'd1;
    logic [BURST_W-1:0] burst_slices = '0;
    logic [PAUSE_W-1:0] pause_orbits = '0;
    logic               trig_out, orbit_mark;
    logic [1:0]         run_status;
    logic [CNT_W-1:0]   trig_count;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [7:0] img [DEPTH];
    int c_units, c_loop, c_m, c_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptg_playback_gen #(
        .ADDR_W (ADDR_W), .UNIT (UNIT), .UNITS_W (UNITS_W), .LOOP_W (LOOP_W),
        .BURST_W (BURST_W), .PAUSE_W (PAUSE_W), .CNT_W (CNT_W)
    ) uut (
        .clk (clk), .rst_n (rst_n), .start_cmd (start_cmd), .stop_cmd (stop_cmd),
        .host_we (host_we), .host_addr (host_addr), .host_data (host_data),
        .orbit_units (orbit_units), .loop_orbits (loop_orbits),
        .burst_slices (burst_slices), .pause_orbits (pause_orbits),
        .trig_out (trig_out), .orbit_mark (orbit_mark),
        .run_status (run_status), .trig_count (trig_count)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Slice address output at cycle t after start, or -1 during a pause
    function automatic int exp_slice(input int t);
        int olen, llen, period, s;
        olen = c_units * UNIT;
        llen = c_loop * olen;
        if (c_m == 0 || c_n == 0) begin
            s = t;
        end else begin
            period = c_m + c_n * olen;
            if ((t % period) >= c_m) return -1;
            s = (t / period) * c_m + (t % period);
        end
        return s % llen;
    endfunction

    task automatic set_cfg(input int u, input int l, input int m, input int n);
        c_units = u; c_loop = l; c_m = m; c_n = n;
        orbit_units  = UNITS_W'(u);
        loop_orbits  = LOOP_W'(l);
        burst_slices = BURST_W'(m);
        pause_orbits = PAUSE_W'(n);
    endtask

    task automatic do_start;
        @(negedge clk); start_cmd = 1'b1;
        @(negedge clk); start_cmd = 1'b0;
    endtask

    task automatic do_stop;
        @(negedge clk); stop_cmd = 1'b1;
        @(negedge clk); stop_cmd = 1'b0;
    endtask

    // Call right after do_start; checks cycles t = 0 .. cycles-1
    task automatic run_check(input int cycles, input string req);
        int cnt = 0;
        for (int t = 0; t < cycles; t++) begin
            int s, s1, et, eo, es;
            @(negedge clk);
            s  = exp_slice(t);
            s1 = exp_slice(t + 1);
            et = (s < 0) ? 0 : int'(img[s][0]);
            eo = (s < 0) ? 0 : int'(img[s][1]);
            es = (s1 < 0) ? 2 : 1;
            check(trig_out === et[0], req, "trig_out", int'(trig_out), et);
            check(orbit_mark === eo[0], req, "orbit_mark", int'(orbit_mark), eo);
            check(run_status === 2'(es), req, "run_status R10", int'(run_status), es);
            check(trig_count === CNT_W'(cnt), "R9", "trig_count", int'(trig_count), cnt);
            cnt += et;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int a = 0; a < DEPTH; a++) img[a] = 8'($urandom);

        // R1: reset state
        repeat (3) @(negedge clk);
        check(run_status === 2'b00, "R1", "run_status", int'(run_status), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(run_status === 2'b00, "R1", "run_status", int'(run_status), 0);
        check(!trig_out && !orbit_mark, "R1", "outputs", int'({orbit_mark, trig_out}), 0);
        check(trig_count === '0, "R1", "trig_count", int'(trig_count), 0);

        // Load image while stopped (R2)
        for (int a = 0; a < DEPTH; a++) begin
            host_we = 1'b1; host_addr = ADDR_W'(a); host_data = img[a];
            @(negedge clk);
        end
        host_we = 1'b0;

        // R3, R4, R6: continuous with M zero, loop of 96
        set_cfg(2, 3, 0, 3);
        do_start; run_check(250, "R3");
        do_stop;

        // R6: N zero
        set_cfg(1, 5, 5, 0);
        do_start; run_check(200, "R6");
        do_stop;

        // R5: pauses of 2 orbits after 40 slices, loop 80
        set_cfg(1, 5, 40, 2);
        do_start; run_check(400, "R5");
        do_stop;

        // R5: burst of a single slice
        set_cfg(1, 2, 1, 1);
        do_start; run_check(120, "R5");
        do_stop;

        // R4: full-memory loop, natural wrap
        set_cfg(4, 16, 0, 0);
        do_start; run_check(1100, "R4");

        // R2: writes while running are ignored
        set_cfg(1, 10, 0, 0);
        do_start;
        for (int a = 0; a < 60; a++) begin
            host_we = 1'b1; host_addr = ADDR_W'(a); host_data = ~img[a];
            @(negedge clk);
        end
        host_we = 1'b0;
        do_stop;
        do_start; run_check(170, "R2");

        // R8: stop clears outputs, stop beats start
        do_stop;
        check(run_status === 2'b00, "R8", "run_status", int'(run_status), 0);
        check(!trig_out && !orbit_mark, "R8", "outputs", int'({orbit_mark, trig_out}), 0);
        @(negedge clk); start_cmd = 1'b1; stop_cmd = 1'b1;
        @(negedge clk); start_cmd = 1'b0; stop_cmd = 1'b0;
        check(run_status === 2'b00, "R8", "start+stop status", int'(run_status), 0);
        @(negedge clk);
        check(!trig_out && !orbit_mark, "R8", "outputs", int'({orbit_mark, trig_out}), 0);

        // R7: restart in the middle of a pause
        set_cfg(1, 4, 10, 2);
        do_start;
        repeat (15) @(negedge clk);
        check(run_status === 2'b10, "R7", "paused before restart", int'(run_status), 2);
        do_start; run_check(200, "R7");
        do_stop;

        // Random configurations
        for (int i = 0; i < 6; i++) begin
            int u, l, m, n;
            u = 1 + int'($urandom_range(3));
            l = 1 + int'($urandom_range(DEPTH / (u * UNIT) - 1));
            m = int'($urandom_range(120));
            n = int'($urandom_range(3));
            set_cfg(u, l, m, n);
            do_start; run_check(600, "R5");
            do_stop;
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule